// File: doc/BRIEF.md
# Narrow-Bus Frame Deserializer

This block sits at the receiving end of a narrow inter-chip bus. The bus carries wide words as a burst of 24-bit beats. Each beat comes with a valid flag and a last-beat flag, and the bus side runs on a fast clock (`clk_bus`). A nine-position gather counter works out which beat of the frame is arriving. A one-of-nine decoder steers each valid beat into its own register in a nine-register assembly bank. When the ninth beat has been taken, the assembled 216-bit word is copied into a hold register and handed to a slow clock domain (`clk_out`). There it appears on `word_data` together with a single-cycle `word_valid` strobe.

The last-beat flag realigns the frame. Whenever a valid beat carries it, the gather counter returns to position 0. If the flag shows up before position 8, the partial frame is thrown away, no strobe is produced and a sticky `frame_err` flag is raised. A dropped or lost beat therefore costs at most the frame it belonged to. The hand-off uses a toggle flag with a two-stage synchroniser. Because of this, completed frames must be separated on the bus by at least 12 `clk_out` periods, so the slow side has copied one word before the hold register changes.

Gather FSM states (bus side):
- `GATH_EMPTY`: position 0.
- `GATH_FILL`: positions 1 to 7.
- `GATH_TAIL`: position 8.

Gather FSM transitions:
- advance: a valid beat without the last flag in EMPTY or FILL.
- complete: any valid beat in TAIL, which goes back to EMPTY.
- abort: a valid beat with the last flag in EMPTY or FILL, which goes back to EMPTY.

Presentation FSM states (output side):
- `PRES_IDLE`.
- `PRES_SHOW`: this state is entered on a detected hand-off toggle and lasts one cycle.

Top module: `nbd_frame_deser`

## Requirements
- R1: While `rst_n` is low and after it is released, `word_valid` is 0, `frame_err` is 0 and `word_data` is all zeros. Reset also returns the gather counter to position 0, so a frame sent after a reset taken mid-frame is assembled correctly.
- R2: A beat with `bus_valid` low neither advances the gather position nor writes any register, whatever its data and last flag.
- R3: The k-th valid beat of a frame (k = 0 to 8) appears in bits [24k+23:24k] of `word_data`.
- R4: A frame of nine valid beats, the ninth carrying `bus_last` = 1, produces exactly one `word_valid` pulse carrying the assembled word. The pulse comes 3 to 5 `clk_out` cycles after the ninth beat.
- R5: `word_valid` is high for exactly one `clk_out` cycle per frame, and `word_data` holds its value between strobes.
- R6: A valid beat with `bus_last` = 1 at positions 0 to 7 discards the partial frame, produces no `word_valid`, and returns the counter to position 0. The next nine-beat frame is then assembled correctly.
- R7: `frame_err` goes to 1 in the `clk_bus` cycle after a discarding beat and stays 1 until reset.
- R8: Nine valid beats with `bus_last` = 0 on the ninth also complete a frame and wrap the counter to position 0.
- R9: On every `clk_bus` cycle with `bus_valid` high, exactly one lane of the bank is written. With `bus_valid` low, none is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Fast bus-side clock |
| clk_out | input | 1 | Slow output-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_data | input | 24 | Beat payload |
| bus_valid | input | 1 | Beat qualifier |
| bus_last | input | 1 | Final beat of a frame (meaningful only with bus_valid) |
| word_data | output | 216 | Rebuilt word, `clk_out` domain |
| word_valid | output | 1 | One-cycle strobe with a new word, `clk_out` domain |
| frame_err | output | 1 | Sticky framing-error flag, `clk_bus` domain |

## Verification
The rebuilt word reaches `word_data` 3 to 5 `clk_out` cycles after the ninth beat. The path is two `clk_bus` registers (completion flag, then the hold register and toggle), two synchroniser stages and the presentation state. The bench therefore scans a window of 12 `clk_out` falling edges after every frame. It counts the cycles with `word_valid` high, requiring exactly one for a good frame and none for a dropped one. It captures `word_data` in the strobe cycle.

`frame_err` is due one `clk_bus` cycle after the bad beat. The bench only samples it once the scan window has closed, well clear of that edge. All inputs change on falling edges of `clk_bus`.

// File: rtl/nbd_pkg.sv
package nbd_pkg;

    // Bus-side gather position classes
    typedef enum logic [1:0] {
        GATH_EMPTY = 2'd0,
        GATH_FILL  = 2'd1,
        GATH_TAIL  = 2'd2
    } gath_state_e;

    // Output-side presentation states
    typedef enum logic {
        PRES_IDLE = 1'b0,
        PRES_SHOW = 1'b1
    } pres_state_e;

endpackage

// File: rtl/nbd_beat_fsm.sv
module nbd_beat_fsm
    import nbd_pkg::*;
#(
    parameter int NBEATS = 9,
    parameter int IDX_W  = $clog2(NBEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_last,
    output logic [IDX_W-1:0] beat_idx,
    output logic             frame_done,
    output logic             frame_bad
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBEATS - 1);

    gath_state_e      st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= GATH_EMPTY;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // Transitions: advance, complete, abort
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        if (beat_valid) begin
            unique case (st_q)
                GATH_EMPTY, GATH_FILL: begin
                    if (beat_last) begin
                        st_d  = GATH_EMPTY;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                        st_d  = (idx_d == LAST_IDX) ? GATH_TAIL : GATH_FILL;
                    end
                end
                GATH_TAIL: begin
                    st_d  = GATH_EMPTY;
                    idx_d = '0;
                end
                default: begin
                    st_d  = GATH_EMPTY;
                    idx_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        beat_idx   = idx_q;
        frame_done = beat_valid && (st_q == GATH_TAIL);
        frame_bad  = beat_valid && beat_last && (st_q != GATH_TAIL);
    end

endmodule

// File: rtl/nbd_lane_decoder.sv
module nbd_lane_decoder #(
    parameter int NBEATS = 9,
    parameter int IDX_W  = $clog2(NBEATS)
) (
    input  logic              en,
    input  logic [IDX_W-1:0]  idx,
    output logic [NBEATS-1:0] sel
);
    for (genvar k = 0; k < NBEATS; k++) begin : g_sel
        assign sel[k] = en && (idx == IDX_W'(k));
    end
endmodule

// File: rtl/nbd_assembly_bank.sv
module nbd_assembly_bank #(
    parameter int BEAT_W = 24,
    parameter int NBEATS = 9,
    localparam int WORD_W = BEAT_W * NBEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBEATS-1:0] sel,
    input  logic [BEAT_W-1:0] beat_data,
    output logic [WORD_W-1:0] word
);
    for (genvar k = 0; k < NBEATS; k++) begin : g_lane
        logic [BEAT_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      lane_q <= '0;
            else if (sel[k]) lane_q <= beat_data;
        end
        assign word[k*BEAT_W +: BEAT_W] = lane_q;
    end
endmodule

// File: rtl/nbd_slow_handoff.sv
module nbd_slow_handoff
    import nbd_pkg::*;
#(
    parameter int WORD_W = 216
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tog_in,
    input  logic [WORD_W-1:0] hold_word,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid
);
    logic        sync1_q, sync2_q, seen_q;
    logic        edge_det;
    pres_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            sync1_q <= tog_in;
            sync2_q <= sync1_q;
            seen_q  <= sync2_q;
        end
    end

    assign edge_det = sync2_q ^ seen_q;

    // State register and word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= PRES_IDLE;
            word_data <= '0;
        end else begin
            st_q <= st_d;
            if (edge_det) word_data <= hold_word;
        end
    end

    always_comb begin
        unique case (st_q)
            PRES_IDLE: st_d = edge_det ? PRES_SHOW : PRES_IDLE;
            PRES_SHOW: st_d = edge_det ? PRES_SHOW : PRES_IDLE;
            default:   st_d = PRES_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        word_valid = (st_q == PRES_SHOW);
    end

endmodule

// File: rtl/nbd_frame_deser.sv
module nbd_frame_deser #(
    parameter int BEAT_W = 24,
    parameter int NBEATS = 9
) (
    input  logic                     clk_bus,
    input  logic                     clk_out,
    input  logic                     rst_n,
    input  logic [BEAT_W-1:0]        bus_data,
    input  logic                     bus_valid,
    input  logic                     bus_last,
    output logic [BEAT_W*NBEATS-1:0] word_data,
    output logic                     word_valid,
    output logic                     frame_err
);
    localparam int WORD_W = BEAT_W * NBEATS;
    localparam int IDX_W  = $clog2(NBEATS);

    logic [IDX_W-1:0]  beat_idx;
    logic [NBEATS-1:0] lane_sel;
    logic [WORD_W-1:0] bank_word;
    logic [WORD_W-1:0] hold_q;
    logic              frame_done, frame_bad;
    logic              done_q, tog_q, err_q;

    nbd_beat_fsm #(.NBEATS(NBEATS), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk_bus),
        .rst_n      (rst_n),
        .beat_valid (bus_valid),
        .beat_last  (bus_last),
        .beat_idx   (beat_idx),
        .frame_done (frame_done),
        .frame_bad  (frame_bad)
    );

    nbd_lane_decoder #(.NBEATS(NBEATS), .IDX_W(IDX_W)) u_dec (
        .en  (bus_valid),
        .idx (beat_idx),
        .sel (lane_sel)
    );

    nbd_assembly_bank #(.BEAT_W(BEAT_W), .NBEATS(NBEATS)) u_bank (
        .clk       (clk_bus),
        .rst_n     (rst_n),
        .sel       (lane_sel),
        .beat_data (bus_data),
        .word      (bank_word)
    );

    // Copy the bank one cycle after the closing beat, once the counter is back at 0
    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            tog_q  <= 1'b0;
            err_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            done_q <= frame_done;
            err_q  <= err_q | frame_bad;
            if (done_q) begin
                hold_q <= bank_word;
                tog_q  <= ~tog_q;
            end
        end
    end

    assign frame_err = err_q;

    nbd_slow_handoff #(.WORD_W(WORD_W)) u_hand (
        .clk        (clk_out),
        .rst_n      (rst_n),
        .tog_in     (tog_q),
        .hold_word  (hold_q),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/nbd_frame_deser_chk.sv
module nbd_frame_deser_chk #(
    parameter int BEAT_W = 24,
    parameter int NBEATS = 9,
    localparam int IDX_W  = $clog2(NBEATS),
    localparam int WORD_W = BEAT_W * NBEATS
) (
    input logic              clk_bus,
    input logic              clk_out,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [NBEATS-1:0] lane_sel,
    input logic [IDX_W-1:0]  beat_idx,
    input logic              frame_bad,
    input logic              frame_err,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data
);
    // R9
    lane_onehot_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        bus_valid |-> ($countones(lane_sel) == 1));

    // R2
    lane_quiet_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        !bus_valid |-> (lane_sel == '0));

    // R6
    idx_range_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        beat_idx <= IDX_W'(NBEATS - 1));

    // R7
    err_set_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        frame_bad |=> frame_err);

    // R7
    err_sticky_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
        !$fell(frame_err));

    // R5
    strobe_single_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R5
    word_hold_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
        !word_valid |-> $stable(word_data));

endmodule

bind nbd_frame_deser nbd_frame_deser_chk #(.BEAT_W(BEAT_W), .NBEATS(NBEATS)) u_chk (
    .clk_bus    (clk_bus),
    .clk_out    (clk_out),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .lane_sel   (lane_sel),
    .beat_idx   (beat_idx),
    .frame_bad  (frame_bad),
    .frame_err  (frame_err),
    .word_valid (word_valid),
    .word_data  (word_data)
);

// File: tb/tb_nbd_frame_deser.sv
module tb_nbd_frame_deser;
    localparam int BW = 24;
    localparam int NB = 9;
    localparam int WW = BW * NB;

    logic          clk_bus = 1'b0;
    logic          clk_out = 1'b0;
    logic          rst_n   = 1'b0;
    logic [BW-1:0] bus_data  = '0;
    logic          bus_valid = 1'b0;
    logic          bus_last  = 1'b0;
    logic [WW-1:0] word_data;
    logic          word_valid;
    logic          frame_err;

    int errors = 0;
    int checks = 0;
    logic          exp_err = 1'b0;
    logic [WW-1:0] last_word = '0;

    always #2.5 clk_bus = ~clk_bus;
    always #20  clk_out = ~clk_out;

    nbd_frame_deser dut (
        .clk_bus    (clk_bus),
        .clk_out    (clk_out),
        .rst_n      (rst_n),
        .bus_data   (bus_data),
        .bus_valid  (bus_valid),
        .bus_last   (bus_last),
        .word_data  (word_data),
        .word_valid (word_valid),
        .frame_err  (frame_err)
    );

    // {beat count, last flag on final beat, idle beats between, seed}
    localparam logic [29:0] VEC [0:6] = '{
        {4'd9, 1'b1, 1'b0, 24'h000001},
        {4'd9, 1'b1, 1'b1, 24'hA5A5A5},
        {4'd9, 1'b0, 1'b0, 24'h123456},
        {4'd4, 1'b1, 1'b0, 24'h777777},
        {4'd9, 1'b1, 1'b0, 24'hFFFFF0},
        {4'd1, 1'b1, 1'b1, 24'h0C0C0C},
        {4'd9, 1'b1, 1'b1, 24'h5A0F33}
    };

    function automatic logic [BW-1:0] beat_val(input logic [BW-1:0] seed, input int k);
        return seed + BW'(k) * 24'h0F1E2D;
    endfunction

    function automatic logic [WW-1:0] frame_word(input logic [BW-1:0] seed);
        logic [WW-1:0] w;
        for (int k = 0; k < NB; k++) w[k*BW +: BW] = beat_val(seed, k);
        return w;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [BW-1:0] d, input logic v, input logic l);
        @(negedge clk_bus);
        bus_data  = d;
        bus_valid = v;
        bus_last  = l;
    endtask

    task automatic idle();
        drive(24'hDEAD00, 1'b0, 1'b0);
    endtask

    task automatic send_frame(input int n, input logic lastf, input logic gap,
                              input logic [BW-1:0] seed);
        for (int k = 0; k < n; k++) begin
            if (gap) drive(~beat_val(seed, k), 1'b0, 1'b1); // R2: ignored beat
            drive(beat_val(seed, k), 1'b1, lastf && (k == n - 1));
        end
        idle();
    endtask

    task automatic scan(output int hits, output logic [WW-1:0] got);
        hits = 0;
        got  = '0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_out);
            if (word_valid) begin
                hits++;
                got = word_data;
            end
        end
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hits;
        logic [WW-1:0] got;

        // R1: reset state
        repeat (4) @(negedge clk_out);
        check(word_valid == 1'b0 && frame_err == 1'b0, "R1 in reset",
              {word_valid, frame_err}, '0);
        check(word_data == '0, "R1 word in reset", word_data, '0);
        @(negedge clk_bus);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_out);
        check(word_valid == 1'b0 && frame_err == 1'b0 && word_data == '0,
              "R1 after release", word_data, '0);

        // Table walk (R2, R3, R4, R6, R7, R8)
        for (int v = 0; v < 7; v++) begin
            int n;
            logic lf, gp, good;
            logic [BW-1:0] sd;
            n  = int'(VEC[v][29:26]);
            lf = VEC[v][25];
            gp = VEC[v][24];
            sd = VEC[v][23:0];
            good = (n == NB);
            send_frame(n, lf, gp, sd);
            scan(hits, got);
            if (good) begin
                check(hits == 1, "R4/R5 strobe count", WW'(hits), WW'(1));
                check(got == frame_word(sd), "R3/R2/R8 word", got, frame_word(sd));
                last_word = frame_word(sd);
            end else begin
                exp_err = 1'b1;
                check(hits == 0, "R6 dropped frame", WW'(hits), '0);
                check(word_data == last_word, "R6 word held", word_data, last_word);
            end
            @(negedge clk_bus);
            check(frame_err == exp_err, "R7 frame_err", WW'(frame_err), WW'(exp_err));
        end

        // R5: invalid beats leave word untouched and produce no strobe
        for (int k = 0; k < 6; k++) drive(24'hBADBAD ^ BW'(k), 1'b0, k[0]);
        idle();
        scan(hits, got);
        check(hits == 0, "R5 no strobe on idle beats", WW'(hits), '0);
        check(word_data == last_word, "R5 word held", word_data, last_word);

        // R1: reset mid-frame clears counter and error flag
        for (int k = 0; k < 5; k++) drive(24'h333333, 1'b1, 1'b0);
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk_out);
        @(negedge clk_bus);
        rst_n = 1'b1;
        exp_err = 1'b0;
        repeat (3) @(negedge clk_out);
        check(frame_err == 1'b0 && word_data == '0, "R1 mid-frame reset",
              word_data, '0);
        send_frame(NB, 1'b1, 1'b0, 24'h600D01);
        scan(hits, got);
        check(hits == 1 && got == frame_word(24'h600D01), "R1 realigned after reset",
              got, frame_word(24'h600D01));

        // R6: last on beat 0 then immediate good frame
        send_frame(1, 1'b1, 1'b0, 24'h111111);
        send_frame(NB, 1'b1, 1'b0, 24'h2B2B2B);
        scan(hits, got);
        check(hits == 1 && got == frame_word(24'h2B2B2B), "R6 realign after short frame",
              got, frame_word(24'h2B2B2B));
        @(negedge clk_bus);
        check(frame_err == 1'b1, "R7 set by last on beat 0", WW'(frame_err), WW'(1));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule